// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers a small set of level-sensitive PCI interrupt request lines onto the inputs of a legacy interrupt controller. Each request line owns one byte-wide route register. A route value below the number of controller inputs names the controller input that the line drives. Any larger value switches the line off: its level is then ignored. A controller input is asserted when at least one line routed to it is high, so several lines can share one input.

Internally the block keeps a level map with one bit per (controller input, request line) pair. The map is rebuilt on every clock from the sampled request levels and the routing in force after that clock, so a route write and a level change both show up at the outputs one clock later. Two combinational helpers sit beside the router. The first returns the decoded route of one request line: an enable flag and the target input, or all ones for a line that is switched off. The second folds a device's interrupt pin into a request line number using the slot number of that device.

Top module: `pirq_router`

## Requirements
- R1: While `rst` is sampled high at a clock edge, every route register becomes 0x80 and `irq_out` becomes all zeros after that edge.
- R2: Route register p (0..3) sits at configuration address 0x60+p. A write with `cfg_wr` high stores `cfg_wdata` there on the clock edge. `cfg_rdata` shows the stored byte unchanged, including bit 7. Any other address reads 0x00, and a write to it changes no route register.
- R3: A route value of 16 or more switches that request line off: whatever its level, it asserts no `irq_out` bit.
- R4: A line with a route value v below 16 whose level is high at a clock edge has `irq_out[v]` high after that edge.
- R5: Each `irq_out` bit is the OR of the levels of all request lines routed to it, so lines that share a target combine.
- R6: A route write takes effect at its own clock edge. The outputs after that edge follow the new routing with the levels sampled at that edge, and the old target drops unless another line still drives it.
- R7: When a line's level falls, its target deasserts one clock later unless another line routed to the same input is still high.
- R8: For the line chosen by `qry_sel`, the query helper gives `qry_en`=1 and `qry_irq`={0, value[3:0]} when the route value is below 16. Otherwise it gives `qry_en`=0 and `qry_irq`=5'h1F, which is -1 in two's complement. The helper is combinational.
- R9: `swz_pirq` = (`swz_pin` + `swz_devfn[7:3]` − 1) mod 4, combinational.
- R10: A reset raised in the middle of operation, with lines high and routed, clears `irq_out` and restores every route to 0x80 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address for reads and writes |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| pirq_lvl | input | 4 | Levels of the PCI interrupt request lines |
| irq_out | output | 16 | Registered interrupt controller inputs |
| qry_sel | input | 2 | Request line whose decoded route is queried |
| qry_en | output | 1 | Queried route is enabled |
| qry_irq | output | 5 | Queried target input, all ones when disabled |
| swz_devfn | input | 8 | Device/function number for the pin fold |
| swz_pin | input | 2 | Device interrupt pin (0..3) |
| swz_pirq | output | 2 | Request line the pin folds onto |

## Verification
Interrupt outputs pass through one register. A level or route change that is present at clock edge N is therefore visible at `irq_out` just after edge N and is compared at the following falling edge. The read-back, query and fold outputs are combinational, so they are compared at that same falling edge against the inputs driven shortly after the rising edge. The reference model updates its route bytes and level map on each rising edge from the inputs held at that edge, and every comparison is made half a period later. No result is ever sampled on an active edge.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

    localparam int unsigned ROUTE_W   = 8;
    localparam logic [ROUTE_W-1:0] ROUTE_OFF = 8'h80;

    typedef logic [ROUTE_W-1:0] route_t;

    typedef struct packed {
        logic       en;
        logic [3:0] irq;
    } route_dec_t;

    // A route byte selects a target only when it names an existing input.
    function automatic logic route_on(route_t r, int unsigned nirq);
        return 32'(r) < nirq;
    endfunction

    // Fold a device interrupt pin onto a request line by its slot number.
    function automatic int unsigned pin_fold(int unsigned slot, int unsigned pin,
                                             int unsigned nlines);
        return (pin + slot + nlines - 1) % nlines;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int unsigned NUM_PIRQ   = 4,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned ROUTE_BASE = 'h60
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ROUTE_W-1:0]        wdata,
    output logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
    output logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx,
    output logic [ROUTE_W-1:0]        rdata
);

    logic [NUM_PIRQ-1:0] hit_wr;
    logic [NUM_PIRQ-1:0] hit_rd;

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_reg
        assign hit_rd[p]   = (addr == ADDR_W'(ROUTE_BASE + p));
        assign hit_wr[p]   = wr && hit_rd[p];
        assign route_nx[p] = hit_wr[p] ? wdata : route_q[p];

        always_ff @(posedge clk) begin
            if (rst) route_q[p] <= ROUTE_OFF;
            else     route_q[p] <= route_nx[p];
        end

        // R2: a route byte moves only on a write to its own address
        p_hold_unwritten_r2: assert property (@(posedge clk) disable iff (rst)
            !(wr && addr == ADDR_W'(ROUTE_BASE + p)) |=> $stable(route_q[p]));
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (hit_rd[p]) rdata = route_q[p];
        end
    end

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_router_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = 4,
    parameter int unsigned NUM_IRQ  = 16,
    localparam int unsigned IRQ_W   = $clog2(NUM_IRQ),
    localparam int unsigned MAP_W   = NUM_IRQ * NUM_PIRQ
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx,
    input  logic [NUM_PIRQ-1:0]              lvl,
    output logic [MAP_W-1:0]                 map_q
);

    logic [MAP_W-1:0] map_d;

    // Full rebuild every cycle: bit index = target * NUM_PIRQ + line.
    always_comb begin
        map_d = '0;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (lvl[p] && route_on(route_nx[p], NUM_IRQ)) begin
                map_d[int'(route_nx[p][IRQ_W-1:0]) * NUM_PIRQ + p] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_d;
    end

endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge #(
    parameter int unsigned NUM_PIRQ = 4,
    parameter int unsigned NUM_IRQ  = 16,
    localparam int unsigned MAP_W   = NUM_IRQ * NUM_PIRQ
) (
    input  logic [MAP_W-1:0]   map_q,
    output logic [NUM_IRQ-1:0] irq
);

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_or
        assign irq[k] = |map_q[k*NUM_PIRQ +: NUM_PIRQ];
    end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int unsigned NUM_PIRQ   = 4,
    parameter int unsigned NUM_IRQ    = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned ROUTE_BASE = 'h60,
    localparam int unsigned PIRQ_W    = $clog2(NUM_PIRQ),
    localparam int unsigned IRQ_W     = $clog2(NUM_IRQ),
    localparam int unsigned QRY_W     = IRQ_W + 1,
    localparam int unsigned MAP_W     = NUM_IRQ * NUM_PIRQ
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic [NUM_PIRQ-1:0] pirq_lvl,
    output logic [NUM_IRQ-1:0] irq_out,
    input  logic [PIRQ_W-1:0]  qry_sel,
    output logic               qry_en,
    output logic [QRY_W-1:0]   qry_irq,
    input  logic [7:0]         swz_devfn,
    input  logic [PIRQ_W-1:0]  swz_pin,
    output logic [PIRQ_W-1:0]  swz_pirq
);

    logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;
    logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx;
    logic [MAP_W-1:0]                 map_q;
    route_dec_t                       qdec;
    logic                             all_off;

    pirq_route_regs #(
        .NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W), .ROUTE_BASE(ROUTE_BASE)
    ) i_regs (
        .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .route_q(route_q), .route_nx(route_nx), .rdata(cfg_rdata)
    );

    pirq_level_map #(
        .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)
    ) i_map (
        .clk(clk), .rst(rst), .route_nx(route_nx), .lvl(pirq_lvl), .map_q(map_q)
    );

    pirq_irq_merge #(
        .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)
    ) i_merge (
        .map_q(map_q), .irq(irq_out)
    );

    // Route query helper
    always_comb begin
        qdec.en  = route_on(route_q[qry_sel], NUM_IRQ);
        qdec.irq = 4'(route_q[qry_sel][IRQ_W-1:0]);
    end
    assign qry_en  = qdec.en;
    assign qry_irq = qdec.en ? {1'b0, IRQ_W'(qdec.irq)} : '1;

    // Pin fold helper
    assign swz_pirq = PIRQ_W'(pin_fold(32'(swz_devfn[7:3]), 32'(swz_pin), NUM_PIRQ));

    always_comb begin
        all_off = 1'b1;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (route_on(route_q[p], NUM_IRQ)) all_off = 1'b0;
        end
    end

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_chk
        // R4: a high, routed line drives its target after the next edge
        p_routed_drives_r4: assert property (@(posedge clk) disable iff (rst)
            (route_on(route_q[p], NUM_IRQ) && pirq_lvl[p] && !cfg_wr)
            |=> irq_out[$past(route_q[p][IRQ_W-1:0])]);
    end

    // R3: with every line switched off and no write, nothing is driven
    p_all_off_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (all_off && !cfg_wr) |=> (irq_out == '0));

    // R5: at most one output per request line can be asserted
    p_fanout_bound_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_out) <= NUM_PIRQ);

    // R8: an enabled query result names an output that the line really drives
    p_query_target_r8: assert property (@(posedge clk) disable iff (rst)
        (qry_en && pirq_lvl[qry_sel] && !cfg_wr)
        |=> irq_out[$past(qry_irq[IRQ_W-1:0])]);

endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic [7:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic [3:0] pirq_lvl;
    logic [15:0] irq_out;
    logic [1:0] qry_sel;
    logic       qry_en;
    logic [4:0] qry_irq;
    logic [7:0] swz_devfn;
    logic [1:0] swz_pin;
    logic [1:0] swz_pirq;

    int unsigned n_cmp  = 0;
    int unsigned n_bad  = 0;
    string       phase  = "R1";
    bit          mvalid = 1'b0;
    bit          done   = 1'b0;

    int          m_route [4];
    logic [15:0] m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    pirq_router i_pirq_router (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pirq_lvl(pirq_lvl),
        .irq_out(irq_out), .qry_sel(qry_sel), .qry_en(qry_en), .qry_irq(qry_irq),
        .swz_devfn(swz_devfn), .swz_pin(swz_pin), .swz_pirq(swz_pirq)
    );

    // Behavioural reference: route bytes and the level bitmap, one edge at a time.
    always @(posedge clk) begin
        logic [63:0] bm;
        if (rst) begin
            foreach (m_route[i]) m_route[i] = 'h80;
            m_irq = '0;
        end else begin
            if (cfg_wr && cfg_addr >= 8'h60 && cfg_addr <= 8'h63)
                m_route[cfg_addr - 8'h60] = int'(cfg_wdata);
            bm = '0;
            for (int p = 0; p < 4; p++)
                if (pirq_lvl[p] && m_route[p] < 16) bm[m_route[p]*4 + p] = 1'b1;
            for (int k = 0; k < 16; k++) m_irq[k] = |bm[k*4 +: 4];
        end
        mvalid = 1'b1;
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mvalid && !done) begin
            int exp_rd, r, exp_fold;
            check(irq_out === m_irq, {phase, " irq_out"}, int'(irq_out), int'(m_irq));
            exp_rd = (cfg_addr >= 8'h60 && cfg_addr <= 8'h63) ? m_route[cfg_addr - 8'h60] : 0;
            check(cfg_rdata === 8'(exp_rd), "R2 cfg_rdata", int'(cfg_rdata), exp_rd);
            r = m_route[qry_sel];
            check(qry_en === (r < 16), "R8 qry_en", int'(qry_en), int'(r < 16));
            check(qry_irq === ((r < 16) ? 5'(r) : 5'h1F), "R8 qry_irq",
                  int'(qry_irq), (r < 16) ? r : 31);
            exp_fold = (int'(swz_pin) + int'(swz_devfn[7:3]) + 3) % 4;
            check(swz_pirq === 2'(exp_fold), "R9 swz_pirq", int'(swz_pirq), exp_fold);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = 8'h60; cfg_wdata = '0;
        pirq_lvl = 4'hF; qry_sel = '0; swz_devfn = '0; swz_pin = '0;
        // R1: reset state of routes and outputs
        for (int i = 0; i < 4; i++) begin
            cfg_addr = 8'(8'h60 + i); qry_sel = 2'(i); tick();
        end
        rst = 1'b0;
        // R3: every line switched off at 0x80, levels high
        phase = "R3";
        repeat (3) tick();
        wr(8'h62, 8'h8E);
        wr(8'h63, 8'h10);
        repeat (2) tick();
        // R2: program routes, stray writes elsewhere, read back
        phase = "R2";
        wr(8'h60, 8'h05); wr(8'h61, 8'h0A); wr(8'h62, 8'h8E); wr(8'h63, 8'h0F);
        wr(8'h64, 8'h33); wr(8'h5F, 8'h01);
        for (int a = 8'h5E; a <= 8'h66; a++) begin
            cfg_addr = 8'(a); tick();
        end
        // R4: single lines, including the disabled one
        phase = "R4";
        for (int p = 0; p < 4; p++) begin
            pirq_lvl = 4'(1 << p); qry_sel = 2'(p); tick(); tick();
        end
        // R5: two lines share target 5
        phase = "R5";
        wr(8'h61, 8'h05);
        pirq_lvl = 4'b0001; tick();
        pirq_lvl = 4'b0011; tick();
        pirq_lvl = 4'b0010; tick();
        // R7: falling levels with and without a sharer
        phase = "R7";
        pirq_lvl = 4'b0011; tick();
        pirq_lvl = 4'b0001; tick();
        pirq_lvl = 4'b0000; tick(); tick();
        // R6: reroute while the level stays high
        phase = "R6";
        pirq_lvl = 4'b1001; tick();
        wr(8'h60, 8'h03); tick();
        wr(8'h63, 8'h9F); tick();
        wr(8'h63, 8'h00); tick();
        // R9: fold sweep over slots and pins
        phase = "R9";
        for (int s = 0; s < 32; s++)
            for (int pin = 0; pin < 4; pin++) begin
                swz_devfn = 8'((s << 3) | (s & 7)); swz_pin = 2'(pin); tick();
            end
        // R5: mixed random traffic
        phase = "R5";
        for (int i = 0; i < 400; i++) begin
            pirq_lvl = 4'($urandom);
            qry_sel  = 2'($urandom);
            cfg_addr = 8'(8'h5E + $urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) begin
                cfg_wr = 1'b1;
                cfg_wdata = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
            end else cfg_wr = 1'b0;
            tick();
        end
        cfg_wr = 1'b0;
        // R10: reset in mid run with routed lines high
        phase = "R10";
        wr(8'h60, 8'h02); wr(8'h61, 8'h07);
        pirq_lvl = 4'hF; tick();
        rst = 1'b1; cfg_addr = 8'h61; tick();
        rst = 1'b0; tick(); tick();
        finish_run();
    end

endmodule